// File: doc/BRIEF.md
# Receive Idle-Line Detector

This block sits behind a serial receiver's bit sampler and reports when the receive line has gone quiet after traffic. For every bit time the sampler gives one strobe together with the decided bit value. The frame logic also marks the start bit and the stop bit. The detector counts consecutive high bit times. When the count reaches one full character time it raises a one-cycle idle pulse.

One mode bit sets where counting may begin. With the bit cleared, high bits count from just after the start bit, so the high data bits at the end of a character and its stop bit already add to the count. With the bit set, nothing inside a frame counts, and counting starts from zero only after the stop bit. A second mode bit sets the frame length, and so the threshold. After a pulse the detector is disarmed. It stays disarmed until a re-arm pulse reports that a new character was received. It is also disarmed after reset, so a line that is idle at power-up gives no report.

Top module: `rx_idle_detect`

## Requirements
- R1: The threshold is DATA_BITS+2 counted high bit times (10 with the default DATA_BITS=8) when `longFrame` is 0. It is DATA_BITS+3 (11) when `longFrame` is 1. A frame then carries DATA_BITS or DATA_BITS+1 data bits, sent least significant bit first.
- R2: With `idleAfterStop`=0, every high bit time counts from the bit after the start bit onward. Trailing high data bits and the stop bit therefore count toward the threshold.
- R3: With `idleAfterStop`=1, no bit time from a `startPulse` through the `stopPulse` counts. The stop bit clears the count, so counting begins with the first bit time after the stop bit.
- R4: A bit strobe with `bitValue`=0 sets the count of high bit times back to zero.
- R5: `idlePulse` is high for exactly one clock cycle. That cycle follows the clock edge that samples the bit strobe completing the threshold.
- R6: Once it has fired, the detector gives no further pulse while the line stays high, however long that lasts.
- R7: A `rearm` pulse enables the next detection. A re-arm that arrives while the count is already at the threshold gives no pulse until a low bit restarts the count.
- R8: `idlePulse` is 0 during reset. After reset the detector is disarmed, so an all-high line gives no pulse before the first `rearm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitStrobe | input | 1 | One-cycle strobe, one per bit time |
| bitValue | input | 1 | Sampled line level for the strobed bit |
| startPulse | input | 1 | Marks the start-bit strobe of a frame |
| stopPulse | input | 1 | Marks the stop-bit strobe of a frame |
| idleAfterStop | input | 1 | 0: count from after the start bit; 1: count only after the stop bit |
| longFrame | input | 1 | 0: short frame threshold; 1: long frame threshold |
| rearm | input | 1 | A new character was received; arms detection |
| idlePulse | output | 1 | One-cycle idle-line report |

## Verification
The assertions rely on the mode bits staying constant while a detection is in progress. They also rely on `startPulse` and `stopPulse` arriving only in the same cycle as a bit strobe, never together. The stimulus follows these rules. It changes the modes only between test cases, while no strobe is active. It puts the frame markers and `rearm` on the strobe of the start bit or stop bit they belong to. It leaves one quiet cycle between strobes, so the cycle after each pulse can be checked on its own.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;
  // Strobes passed from the arming control to the counting datapath.
  typedef struct packed {
    logic cntEn;   // a high bit time may advance the count
    logic clrCnt;  // force the count back to zero
  } idleCtrl_t;
endpackage

// File: rtl/idle_count_dp.sv
module idle_count_dp
  import rx_idle_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitStrobe,
  input  logic      bitValue,
  input  logic      longFrame,
  input  idleCtrl_t ctrl,
  output logic      reachTh
);
  localparam int SHORT_TH = DATA_BITS + 2;
  localparam int LONG_TH  = DATA_BITS + 3;
  localparam int CNT_W    = $clog2(LONG_TH + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] thr;

  always_comb begin
    thr = longFrame ? CNT_W'(LONG_TH) : CNT_W'(SHORT_TH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctrl.clrCnt) begin
      cnt <= '0;
    end else if (bitStrobe) begin
      if (!bitValue) begin
        cnt <= '0;
      end else if (ctrl.cntEn && (cnt < thr)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // The strobe that takes the count onto the threshold.
  always_comb begin
    reachTh = bitStrobe && bitValue && ctrl.cntEn && !ctrl.clrCnt
              && (cnt == thr - 1'b1);
  end

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(LONG_TH));

  a_r4_low_clears: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && !bitValue) |=> (cnt == '0));

  a_r3_gated_no_growth: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.cntEn) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/idle_arm_ctrl.sv
module idle_arm_ctrl
  import rx_idle_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      stopPulse,
  input  logic      idleAfterStop,
  input  logic      rearm,
  input  logic      reachTh,
  output idleCtrl_t ctrl,
  output logic      idlePulse
);
  logic inFrame;
  logic armed;
  logic fire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
    end else if (stopPulse) begin
      inFrame <= 1'b0;
    end else if (startPulse) begin
      inFrame <= 1'b1;
    end
  end

  always_comb begin
    ctrl.cntEn  = !idleAfterStop || (!inFrame && !startPulse && !stopPulse);
    ctrl.clrCnt = idleAfterStop && stopPulse;
    fire        = armed && reachTh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      idlePulse <= 1'b0;
    end else begin
      idlePulse <= fire;
      if (rearm) begin
        armed <= 1'b1;
      end else if (fire) begin
        armed <= 1'b0;
      end
    end
  end

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    idlePulse |=> !idlePulse);

  a_r6_disarm_after_fire: assert property (@(posedge clk) disable iff (!rstN)
    (idlePulse && !$past(rearm)) |-> !armed);

  a_r8_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    (!armed) |=> !idlePulse);

  a_r3_frame_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (idleAfterStop && inFrame && !stopPulse) |-> !reachTh);
endmodule

// File: rtl/rx_idle_detect.sv
module rx_idle_detect
  import rx_idle_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitStrobe,
  input  logic bitValue,
  input  logic startPulse,
  input  logic stopPulse,
  input  logic idleAfterStop,
  input  logic longFrame,
  input  logic rearm,
  output logic idlePulse
);
  idleCtrl_t ctrl;
  logic      reachTh;

  idle_arm_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startPulse   (startPulse),
    .stopPulse    (stopPulse),
    .idleAfterStop(idleAfterStop),
    .rearm        (rearm),
    .reachTh      (reachTh),
    .ctrl         (ctrl),
    .idlePulse    (idlePulse)
  );

  idle_count_dp #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .bitStrobe(bitStrobe),
    .bitValue (bitValue),
    .longFrame(longFrame),
    .ctrl     (ctrl),
    .reachTh  (reachTh)
  );
endmodule

// File: tb/rx_idle_detect_bench.sv
`timescale 1ns/1ps
module rx_idle_detect_bench;
  localparam int DATA_BITS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitStrobe = 1'b0, bitValue = 1'b1;
  logic startPulse = 1'b0, stopPulse = 1'b0, rearm = 1'b0;
  logic idleAfterStop = 1'b0, longFrame = 1'b0;
  logic idlePulse;

  int nTests = 0;
  int nFail = 0;
  int pulses;
  int firstIdx;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_idle_detect #(.DATA_BITS(DATA_BITS)) u_rx_idle_detect (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .bitValue(bitValue),
    .startPulse(startPulse), .stopPulse(stopPulse),
    .idleAfterStop(idleAfterStop), .longFrame(longFrame),
    .rearm(rearm), .idlePulse(idlePulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One strobed bit, then a quiet cycle. Returns whether a pulse followed it.
  task automatic sendBit(input logic v, input logic st, input logic sp,
                         input logic rr, output logic got);
    @(negedge clk);
    bitStrobe = 1'b1; bitValue = v; startPulse = st; stopPulse = sp; rearm = rr;
    @(negedge clk);
    bitStrobe = 1'b0; bitValue = 1'b1; startPulse = 1'b0; stopPulse = 1'b0; rearm = 1'b0;
    got = idlePulse;
    @(negedge clk);
    if (got) check(idlePulse == 1'b0, "R5 pulse width", int'(idlePulse), 0);
  endtask

  task automatic idleBits(input int n);
    logic g;
    for (int i = 1; i <= n; i++) begin
      sendBit(1'b1, 1'b0, 1'b0, 1'b0, g);
      if (g) begin
        if (pulses == 0) firstIdx = i;
        pulses++;
      end
    end
  endtask

  task automatic sendFrame(input logic [DATA_BITS:0] data, input int nb);
    logic g;
    sendBit(1'b0, 1'b1, 1'b0, 1'b0, g);
    if (g) pulses++;
    for (int i = 0; i < nb; i++) begin
      sendBit(data[i], 1'b0, 1'b0, 1'b0, g);
      if (g) pulses++;
    end
    sendBit(1'b1, 1'b0, 1'b1, 1'b1, g);
    if (g) pulses++;
  endtask

  function automatic int trailingOnes(input logic [DATA_BITS:0] d, input int nb);
    int t = 0;
    for (int i = nb - 1; i >= 0; i--) begin
      if (!d[i]) break;
      t++;
    end
    return t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic g;
    logic [DATA_BITS:0] pat;
    int nb, thr, k, t, expP;

    repeat (3) @(negedge clk);
    check(idlePulse == 1'b0, "R8 reset value", int'(idlePulse), 0);
    rstN = 1'b1;

    // R8: idle line after reset, never armed.
    pulses = 0; firstIdx = 0;
    idleBits(25);
    check(pulses == 0, "R8 disarmed after reset", pulses, 0);

    // Sweep: modes (R2, R3), frame lengths (R1), data patterns, idle lengths.
    for (int m = 0; m < 2; m++) begin
      for (int lf = 0; lf < 2; lf++) begin
        idleAfterStop = m[0];
        longFrame = lf[0];
        nb = DATA_BITS + lf;
        thr = DATA_BITS + 2 + lf;
        for (int p = 0; p < 4; p++) begin
          case (p)
            0: pat = '1;
            1: pat = '0;
            2: pat = {(DATA_BITS+1){1'b1}} << (nb / 2);
            default: pat = {((DATA_BITS+2)/2){2'b01}};
          endcase
          t = (m == 0) ? trailingOnes(pat, nb) + 1 : 0;
          k = thr - t;
          for (int n = 0; n <= thr + 2; n++) begin
            pulses = 0; firstIdx = 0;
            sendFrame(pat, nb);
            idleBits(n);
            expP = (n >= k) ? 1 : 0;
            if (m == 0)
              check(pulses == expP, "R2 pulse count", pulses, expP);
            else
              check(pulses == expP, "R3 pulse count", pulses, expP);
            if (expP == 1)
              check(firstIdx == k, "R1 threshold position", firstIdx, k);
          end
        end
      end
    end

    // R6 / R7 / R4 directed cases in each mode and frame length.
    for (int m = 0; m < 2; m++) begin
      for (int lf = 0; lf < 2; lf++) begin
        idleAfterStop = m[0];
        longFrame = lf[0];
        nb = DATA_BITS + lf;
        thr = DATA_BITS + 2 + lf;

        pulses = 0; firstIdx = 0;
        sendFrame('0, nb);
        idleBits(40);
        check(pulses == 1, "R6 single report on long idle", pulses, 1);

        // Re-arm while saturated: no pulse without a low bit.
        sendBit(1'b1, 1'b0, 1'b0, 1'b1, g);
        check(g == 1'b0, "R7 rearm strobe", int'(g), 0);
        pulses = 0; firstIdx = 0;
        idleBits(20);
        check(pulses == 0, "R7 saturated rearm", pulses, 0);

        // A low bit restarts the count; armed state still holds.
        sendBit(1'b0, 1'b0, 1'b0, 1'b0, g);
        pulses = 0; firstIdx = 0;
        idleBits(thr + 3);
        check(pulses == 1 && firstIdx == thr, "R4 restart after low",
              firstIdx, thr);

        // Interrupted idle: partial run, low bit, then a full run.
        pulses = 0; firstIdx = 0;
        sendFrame('0, nb);
        idleBits(thr - 3);
        check(pulses == 0, "R4 partial run", pulses, 0);
        sendBit(1'b0, 1'b0, 1'b0, 1'b0, g);
        pulses = 0; firstIdx = 0;
        idleBits(thr);
        check(pulses == 1 && firstIdx == thr, "R4 low bit resets count",
              firstIdx, thr);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule